// File: doc/BRIEF.md
# Two-Wire Bus Slave for a Paged Register Bank

This block is a slave on a two-wire serial bus (SCL clock line, SDA data line). It gives a bus host read and write access to a bank of 64 eight-bit registers. The registers live outside the block and are reached through a plain register-file port. There is a registered write strobe with its own address and data. There is also a read address that always equals the internal register pointer, and the register file returns the byte for it combinationally.

Both bus lines are oversampled on the system clock through a small synchronizer. START and STOP are found from SDA edges while SCL is high. Bits are taken on SCL rising edges and driven after SCL falling edges. The slave only ever pulls SDA low, through an output-enable. The host chooses a register with a pointer byte, then writes one or more bytes, or re-addresses with a repeated START and reads one or more bytes. The pointer advances only inside its 16-register page. One input strap picks the lowest address bit, so two of these slaves can share a bus.

Top module: `serialRegSlave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 0,1,0,0,1,0 followed by the level of `addrSel`, sent MSB first. For any other address it drives nothing and ignores the bus until the next START.
- R2: All bytes move MSB first, in both directions.
- R3: In a write transaction (address with R/W bit 0, pointer byte, data bytes), the slave stores each data byte at the current pointer and acknowledges it. Exactly one `regWrEn` pulse is produced per byte, and the pulse falls in the acknowledge slot.
- R4: After a pointer-setting write header, a repeated START, and the address with R/W bit 1, the slave returns the register bytes that start at that pointer.
- R5: A host ACK (SDA low) after a read byte makes the slave send the next byte. A host NACK makes it release SDA and stay silent until a STOP or a START.
- R6: After every byte written or read, only pointer bits [3:0] increment, wrapping from 0xF to 0x0. Bits [5:4] keep their value.
- R7: The pointer byte is always acknowledged. Only its bits [5:0] are loaded, and bits [7:6] have no effect.
- R8: A START or STOP at any bit position abandons the byte in progress. An incomplete data byte is never written.
- R9: `sdaOe` changes only while SCL is low, so the slave never makes a START or STOP of its own.
- R10: Out of reset, `sdaOe`, `regWrEn` and the pointer (`regRdAddr`) are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| addrSel | input | 1 | Strap that sets the lowest device address bit |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | 6 | Register index for the write strobe |
| regWrData | output | 8 | Byte to store |
| regRdAddr | output | 6 | Current register pointer, used as read index |
| regRdData | input | 8 | Register byte at `regRdAddr` |

## Verification
The bench aims bursts at pointers such as 0x3E and 0x1D, so that they run past the end of a page. A design that carried into bit 4 would write or return registers in the next page. It sends pointer bytes with bits [7:6] set, addresses with the strap bit wrong, and data bytes cut off by a STOP after a few bits. A faulty slave would then land on the wrong register, acknowledge a foreign address, or commit a partial byte. After a host NACK it keeps clocking the bus. A slave that missed the NACK would keep pulling SDA and return data other than all ones.

// File: rtl/serialRegPkg.sv
package serialRegPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } busState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrCnt;   // restart the bit counter
    logic shiftIn;  // take one received bit
    logic loadPtr;  // pointer <= received byte
    logic wrStb;    // commit received byte, then advance pointer
    logic incPtr;   // advance pointer after a read byte
    logic loadTx;   // fetch register byte into the transmit shifter
    logic shiftTx;  // present next transmit bit
  } dpStrobe_t;

endpackage

// File: rtl/serialLineSync.sv
module serialLineSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [1:0] lineIn;
  logic [PIPE_W-1:0] pipe [2];
  logic [1:0] cur;
  logic [1:0] prev;

  assign lineIn = {sclIn, sdaIn};

  // index 1 = SCL, index 0 = SDA; idle bus is high
  for (genvar g = 0; g < 2; g++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[g] <= '1;
      else       pipe[g] <= {pipe[g][PIPE_W-2:0], lineIn[g]};
    end
    assign cur[g]  = pipe[g][PIPE_W-2];
    assign prev[g] = pipe[g][PIPE_W-1];
  end

  assign sdaLvl   = cur[0];
  assign sclRise  = cur[1] & ~prev[1];
  assign sclFall  = ~cur[1] & prev[1];
  assign startDet = cur[1] & prev[1] & prev[0] & ~cur[0];
  assign stopDet  = cur[1] & prev[1] & ~prev[0] & cur[0];

endmodule

// File: rtl/serialSlaveData.sv
module serialSlaveData
  import serialRegPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_AW    = 6,
  parameter int PAGE_BITS = 4,
  localparam int CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaLvl,
  input  logic [DATA_W-1:0] regRdData,
  output logic              byteDone,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit,
  output logic              regWrEn,
  output logic [REG_AW-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic [REG_AW-1:0] regPtr
);
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic [REG_AW-1:0] ptrNext;

  // pointer advance stays inside one page
  if (PAGE_BITS >= REG_AW) begin : gFlatPtr
    assign ptrNext = regPtr + REG_AW'(1);
  end else begin : gPagedPtr
    assign ptrNext = {regPtr[REG_AW-1:PAGE_BITS],
                      regPtr[PAGE_BITS-1:0] + PAGE_BITS'(1)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '1;
      regPtr    <= '0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      if (stb.clrCnt) begin
        bitCnt <= '0;
      end else if (stb.shiftIn) begin
        rxShift <= {rxShift[DATA_W-2:0], sdaLvl};
        bitCnt  <= bitCnt + CNT_W'(1);
      end

      if (stb.loadPtr)                  regPtr <= rxShift[REG_AW-1:0];
      else if (stb.wrStb || stb.incPtr) regPtr <= ptrNext;

      regWrEn <= stb.wrStb;
      if (stb.wrStb) begin
        regWrAddr <= regPtr;
        regWrData <= rxShift;
      end

      if (stb.loadTx)       txShift <= regRdData;
      else if (stb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end

  assign byteDone = (bitCnt == CNT_W'(DATA_W));
  assign rxByte   = rxShift;
  assign txBit    = txShift[DATA_W-1];

endmodule

// File: rtl/serialSlaveCtrl.sv
module serialSlaveCtrl
  import serialRegPkg::*;
#(
  parameter int DATA_W                 = 8,
  parameter logic [DATA_W-3:0] ADDR_HI = 6'b010010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaLvl,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  input  logic              addrSel,
  output dpStrobe_t         stb,
  output logic              sdaOe
);
  busState_e state, stateNext;
  logic      rdMode, rdModeNext;
  logic      hostAck, hostAckNext;
  logic      addrMatch;

  assign addrMatch = (rxByte[DATA_W-1:1] == {ADDR_HI, addrSel});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rdMode  <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= stateNext;
      rdMode  <= rdModeNext;
      hostAck <= hostAckNext;
    end
  end

  always_comb begin
    stateNext   = state;
    rdModeNext  = rdMode;
    hostAckNext = hostAck;
    stb         = '0;

    if (startDet) begin
      stateNext  = ST_ADDR;
      stb.clrCnt = 1'b1;
    end else if (stopDet) begin
      stateNext  = ST_IDLE;
      stb.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;

        ST_ADDR, ST_REG, ST_WDATA: begin
          if (sclRise && !byteDone) stb.shiftIn = 1'b1;
          if (sclFall && byteDone) begin
            stb.clrCnt = 1'b1;
            if (state == ST_ADDR) begin
              if (addrMatch) begin
                stateNext  = ST_ADDR_ACK;
                rdModeNext = rxByte[0];
              end else begin
                stateNext = ST_IDLE;
              end
            end else if (state == ST_REG) begin
              stb.loadPtr = 1'b1;
              stateNext   = ST_REG_ACK;
            end else begin
              stb.wrStb = 1'b1;
              stateNext = ST_WDATA_ACK;
            end
          end
        end

        ST_ADDR_ACK: begin
          if (sclFall) begin
            stb.clrCnt = 1'b1;
            if (rdMode) begin
              stb.loadTx = 1'b1;
              stateNext  = ST_RDATA;
            end else begin
              stateNext = ST_REG;
            end
          end
        end

        ST_REG_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            stb.clrCnt = 1'b1;
            stateNext  = ST_WDATA;
          end
        end

        ST_RDATA: begin
          if (sclRise && !byteDone) stb.shiftIn = 1'b1;
          if (sclFall) begin
            if (byteDone) begin
              stb.clrCnt  = 1'b1;
              stb.incPtr  = 1'b1;
              hostAckNext = 1'b0;
              stateNext   = ST_RDATA_ACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end

        ST_RDATA_ACK: begin
          if (sclRise) hostAckNext = ~sdaLvl;
          if (sclFall) begin
            if (hostAck) begin
              stb.loadTx = 1'b1;
              stateNext  = ST_RDATA;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end

        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_ADDR_ACK, ST_REG_ACK, ST_WDATA_ACK: sdaOe = 1'b1;
      ST_RDATA:                              sdaOe = ~txBit;
      default:                               sdaOe = 1'b0;
    endcase
  end

endmodule

// File: rtl/serialRegSlave.sv
module serialRegSlave
  import serialRegPkg::*;
#(
  parameter int DATA_W                 = 8,
  parameter int REG_AW                 = 6,
  parameter int PAGE_BITS              = 4,
  parameter int SYNC_STAGES            = 2,
  parameter logic [DATA_W-3:0] ADDR_HI = 6'b010010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              addrSel,
  output logic              regWrEn,
  output logic [REG_AW-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic [REG_AW-1:0] regRdAddr,
  input  logic [DATA_W-1:0] regRdData
);
  logic              sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic              byteDone, txBit;
  logic [DATA_W-1:0] rxByte;
  dpStrobe_t         stb;

  serialLineSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  serialSlaveCtrl #(.DATA_W(DATA_W), .ADDR_HI(ADDR_HI)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .byteDone(byteDone), .rxByte(rxByte), .txBit(txBit),
    .addrSel(addrSel), .stb(stb), .sdaOe(sdaOe)
  );

  serialSlaveData #(.DATA_W(DATA_W), .REG_AW(REG_AW), .PAGE_BITS(PAGE_BITS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(sdaLvl),
    .regRdData(regRdData), .byteDone(byteDone), .rxByte(rxByte),
    .txBit(txBit), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regPtr(regRdAddr)
  );

endmodule

// File: rtl/serialRegSlaveChk.sv
module serialRegSlaveChk #(
  parameter int REG_AW    = 6,
  parameter int PAGE_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regWrAddr,
  input logic [REG_AW-1:0] regRdAddr
);
  logic [PAGE_BITS-1:0] wrLowNext;
  assign wrLowNext = regWrAddr[PAGE_BITS-1:0] + PAGE_BITS'(1);

  // R3: one strobe per byte
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R3: the write lands while the acknowledge is being driven
  assert_wr_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> sdaOe);

  // R6: pointer after a write is the written index advanced inside its page
  assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regRdAddr[REG_AW-1:PAGE_BITS] == regWrAddr[REG_AW-1:PAGE_BITS])
             && (regRdAddr[PAGE_BITS-1:0] == wrLowNext));

  // R9: SDA drive changes only with SCL low
  assert_sda_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

endmodule

bind serialRegSlave serialRegSlaveChk #(.REG_AW(REG_AW), .PAGE_BITS(PAGE_BITS)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .regWrEn(regWrEn),
  .regWrAddr(regWrAddr), .regRdAddr(regRdAddr)
);

// File: tb/serialRegSlave_test.sv
module serialRegSlave_test;
  localparam int Q = 6;              // system clocks per quarter bus bit
  localparam logic [5:0] DEV_HI = 6'b010010;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic sdaLine;
  logic sdaOe, regWrEn;
  logic [5:0] regWrAddr, regRdAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] regFile [64];
  logic [7:0] expMem [64];
  int checks = 0;
  int fails = 0;
  int badEdges = 0;
  bit finished = 0;
  logic prevOe = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  assign sdaLine = sdaM & ~sdaOe;
  assign regRdData = regFile[regRdAddr];

  serialRegSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrSel(addrSel), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  always @(posedge clk) if (regWrEn) regFile[regWrAddr] <= regWrData;

  // R9 monitor: drive changes seen while the bus clock is high
  always @(negedge clk) begin
    if (rstN && sdaOe !== prevOe && sclM) badEdges++;
    prevOe <= sdaOe;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] stepPtr(input logic [5:0] p);
    return {p[5:4], p[3:0] + 4'd1};
  endfunction

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b1; waitQ(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      sdaM = b[i]; waitQ(Q);
      sclM = 1'b1; waitQ(Q);
      sclM = 1'b0; waitQ(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackLvl);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q / 2);
    ackLvl = sdaLine;
    waitQ(Q - Q / 2);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(Q);
      sclM = 1'b1; waitQ(Q / 2);
      b[i] = sdaLine;
      waitQ(Q - Q / 2);
      sclM = 1'b0;
    end
    waitQ(1);
    sdaM = ackIt ? 1'b0 : 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
    sdaM = 1'b1;
  endtask

  task automatic checkImage(input string req);
    int bad = 0;
    int first = 0;
    for (int i = 63; i >= 0; i--) begin
      if (regFile[i] !== expMem[i]) begin bad++; first = i; end
    end
    check(bad == 0, req, "register image", int'(regFile[first]), int'(expMem[first]));
  endtask

  task automatic doWrite(input logic [6:0] dev, input logic [7:0] ptrByte,
                         input int n, input bit expectAck, input string imgReq);
    logic ack;
    logic [5:0] p;
    logic [7:0] d;
    busStart();
    sendByte({dev, 1'b0}, ack);
    check(ack == !expectAck, "R1", "address acknowledge level", ack, !expectAck);
    sendByte(ptrByte, ack);
    if (expectAck) check(ack == 1'b0, "R7", "pointer byte acknowledge", ack, 0);
    else           check(ack == 1'b1, "R1", "foreign pointer byte left unacked", ack, 1);
    p = ptrByte[5:0];
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, ack);
      if (expectAck) begin
        check(ack == 1'b0, "R3", "data byte acknowledge", ack, 0);
        expMem[p] = d;
        p = stepPtr(p);
      end else begin
        check(ack == 1'b1, "R1", "foreign data byte left unacked", ack, 1);
      end
    end
    busStop();
    waitQ(4);
    checkImage(imgReq);
  endtask

  task automatic doRead(input logic [6:0] dev, input logic [7:0] ptrByte,
                        input int n, input bit probeAfterNack);
    logic ack;
    logic [5:0] p;
    logic [7:0] b;
    busStart();
    sendByte({dev, 1'b0}, ack);
    check(ack == 1'b0, "R1", "address acknowledge (read header)", ack, 0);
    sendByte(ptrByte, ack);
    check(ack == 1'b0, "R7", "pointer byte acknowledge (read header)", ack, 0);
    busStart();
    sendByte({dev, 1'b1}, ack);
    check(ack == 1'b0, "R4", "address acknowledge after repeated start", ack, 0);
    p = ptrByte[5:0];
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      check(b == expMem[p], "R2 R4 R6", "read byte", b, expMem[p]);
      p = stepPtr(p);
    end
    check(sdaOe == 1'b0, "R5", "SDA released after NACK", sdaOe, 0);
    if (probeAfterNack) begin
      recvByte(1'b0, b);
      check(b == 8'hFF, "R5", "silent after NACK", b, 8'hFF);
    end
    busStop();
    waitQ(4);
  endtask

  initial begin
    logic ack;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) begin
      regFile[i] = 8'(i * 37 + 11);
      expMem[i]  = 8'(i * 37 + 11);
    end
    waitQ(5);
    // R10: reset state
    check(sdaOe == 1'b0, "R10", "sdaOe in reset", sdaOe, 0);
    check(regWrEn == 1'b0, "R10", "regWrEn in reset", regWrEn, 0);
    check(regRdAddr == 6'd0, "R10", "pointer in reset", regRdAddr, 0);
    rstN = 1'b1;
    waitQ(5);

    // R6: burst write and read across the end of the top page
    doWrite({DEV_HI, 1'b0}, 8'h3E, 4, 1'b1, "R6");
    doRead({DEV_HI, 1'b0}, 8'h3E, 4, 1'b0);
    // R6: burst read wrapping in page 1
    doRead({DEV_HI, 1'b0}, 8'h1D, 5, 1'b0);
    // R7: pointer byte with bits [7:6] set
    doWrite({DEV_HI, 1'b0}, 8'hC5, 2, 1'b1, "R7");
    doRead({DEV_HI, 1'b0}, 8'h05, 2, 1'b0);
    // R1: wrong strap bit and wrong upper address
    doWrite({DEV_HI, 1'b1}, 8'h10, 2, 1'b0, "R1");
    doWrite(7'h2A, 8'h11, 1, 1'b0, "R1");
    // R1: strap high selects the other address
    addrSel = 1'b1; waitQ(2);
    doWrite({DEV_HI, 1'b1}, 8'h22, 3, 1'b1, "R1");
    doWrite({DEV_HI, 1'b0}, 8'h22, 1, 1'b0, "R1");
    addrSel = 1'b0; waitQ(2);
    // R5: keep clocking after NACK
    doRead({DEV_HI, 1'b0}, 8'h20, 2, 1'b1);
    // R8: data byte cut by STOP after three bits
    busStart();
    sendByte({DEV_HI, 1'b0}, ack);
    sendByte(8'h17, ack);
    sendBits(8'h5A, 3);
    busStop();
    waitQ(4);
    checkImage("R8");
    // R8: cut by repeated START, then a clean write
    busStart();
    sendByte({DEV_HI, 1'b0}, ack);
    sendByte(8'h18, ack);
    sendBits(8'h00, 5);
    doWrite({DEV_HI, 1'b0}, 8'h19, 1, 1'b1, "R8");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int kind;
      int n;
      logic [7:0] pb;
      kind = $urandom_range(0, 5);
      n = $urandom_range(1, 6);
      pb = 8'($urandom);
      addrSel = 1'($urandom_range(0, 1));
      waitQ(2);
      if (kind == 0)      doWrite({DEV_HI, ~addrSel}, pb, n, 1'b0, "R1");
      else if (kind <= 2) doWrite({DEV_HI, addrSel}, pb, n, 1'b1, "R3");
      else                doRead({DEV_HI, addrSel}, pb, n, 1'b0);
    end

    check(badEdges == 0, "R9", "SDA drive changes while SCL high", badEdges, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule